// File: doc/BRIEF.md
# Word Register Bank with Bit-Set, Bit-Clear and Bit-Toggle Aliases

This block is a bank of 32-bit control words on a simple word-addressed bus. Most of the bank is made of four-slot groups. The first slot of a group holds the stored word. The three slots that follow it let software set, clear or flip chosen bits of that word in one write, with no read-modify-write sequence. A read of any of the three alias slots returns the stored word. A short redirect-only region follows the groups. In it, reads of the three alias slots also return the group's first word, but writes land as plain writes in the slot that was addressed. The bank ends with plain words.

The first `N_PLL` groups model clock-generator control words. Their reset value always has the lock status bit set. Each accepted request gets exactly one response on the next cycle. A request that is not a full aligned word, or whose word index lies outside the bank, gets an error response with zero data and changes nothing. A small response state machine produces the response. It has four states: `PH_IDLE` (no response), `PH_RD_OK` (read data valid), `PH_WR_OK` (write done) and `PH_FAULT` (error). Each cycle it moves to the state chosen by the current request: no request → `PH_IDLE`, bad access → `PH_FAULT`, good write → `PH_WR_OK`, good read → `PH_RD_OK`. Any state can move to any state.

Top module: `alias_regbank`

## Requirements
- R1: After reset, group 0's first word reads 0x80013001 and group 1's first word reads 0x80011001. These are the clock-generator defaults with lock bit 31 forced on. The other groups' first words read 0x00005A00 ORed with the group number. The first word of the redirect-only region reads 0x00000001, and every plain word reads 0.
- R2: A write to word index 4g+1 (the SET slot) ORs the write data into group g's first word.
- R3: A write to word index 4g+2 (the CLR slot) clears, in group g's first word, every bit that is 1 in the write data.
- R4: A write to word index 4g+3 (the TOG slot) XORs the write data into group g's first word.
- R5: A read of word index 4g+1, 4g+2 or 4g+3 returns the current value of group g's first word.
- R6: A write to a group's first slot, or to a plain word, replaces all 32 bits.
- R7: In the redirect-only region, a read of slot 1, 2 or 3 returns the region's first word. A write to one of those slots does not change the first word.
- R8: An access with `req_size` other than 4 (byte count), with a nonzero `req_addr[1:0]`, or with word index `req_addr>>2` at or beyond the bank size (24 words by default) gives `rsp_err`=1 and `rsp_rdata`=0. A write of that kind changes no word.
- R9: Every request with `req_valid` high gives exactly one response, one cycle later. A write response carries zero data. A write is visible to a read issued on the very next cycle.
- R10: With `req_valid` low, `rsp_valid` is low on the following cycle, and it is low out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset into the bank |
| req_size | input | 3 | Access size in bytes; only 4 is valid |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Error response for a bad access |
| rsp_rdata | output | 32 | Read data, zero on writes and errors |

## Verification
The assertions assume that `req_valid`, `req_write`, `req_addr` and `req_size` are known and steady around each rising edge. They also assume that each cycle carries at most one request. Nothing is assumed about back-pressure, because the bank never stalls. The bench changes inputs only on falling edges and drives one request per cycle. It reaches the bad-size, misaligned and out-of-range cases only through `req_size` and `req_addr`, so every protocol signal stays in its legal form.

// File: rtl/stb_pkg.sv
package stb_pkg;

    localparam int WORD_W = 32;

    // bit operation applied to a stored word; encoding follows slot offset
    typedef enum logic [1:0] {
        OP_PUT = 2'd0,
        OP_SET = 2'd1,
        OP_CLR = 2'd2,
        OP_TOG = 2'd3
    } bitop_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RD_OK = 2'd1,
        PH_WR_OK = 2'd2,
        PH_FAULT = 2'd3
    } phase_e;

    // reset value of word k for a given bank layout
    function automatic logic [WORD_W-1:0] home_value(int k, int n_alias, int n_pll,
                                                     int n_rdo, int lock_bit);
        int alias_end;
        int rdo_end;
        int grp;
        logic [WORD_W-1:0] v;
        alias_end = 4 * n_alias;
        rdo_end   = alias_end + 4 * n_rdo;
        v         = '0;
        if (k < alias_end && (k % 4) == 0) begin
            grp = k / 4;
            if (grp < n_pll) begin
                if (grp == 0)      v = 32'h0001_3001;
                else if (grp == 1) v = 32'h0001_1001;
                else               v = 32'h0001_0000 | WORD_W'(grp);
                v[lock_bit] = 1'b1;
            end else begin
                v = 32'h0000_5A00 | WORD_W'(grp);
            end
        end else if (k >= alias_end && k < rdo_end && ((k - alias_end) % 4) == 0) begin
            v = 32'h0000_0001;
        end
        return v;
    endfunction

endpackage

// File: rtl/stb_decode.sv
module stb_decode
    import stb_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int N_ALIAS = 4,
    parameter int N_RDO   = 1,
    parameter int N_PLAIN = 4,
    localparam int IDX_W  = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output logic              bad,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  wr_idx,
    output bitop_e            op
);
    localparam int TOTAL     = 4 * N_ALIAS + 4 * N_RDO + N_PLAIN;
    localparam int ALIAS_END = 4 * N_ALIAS;
    localparam int RDO_END   = ALIAS_END + 4 * N_RDO;
    localparam logic [IDX_W-1:0] TOTAL_W     = IDX_W'(TOTAL);
    localparam logic [IDX_W-1:0] ALIAS_END_W = IDX_W'(ALIAS_END);
    localparam logic [IDX_W-1:0] RDO_END_W   = IDX_W'(RDO_END);

    logic [IDX_W-1:0] widx;
    logic [IDX_W-1:0] grp_base;

    assign widx     = addr[ADDR_W-1:2];
    assign grp_base = {widx[IDX_W-1:2], 2'b00};
    assign bad      = (size != 3'd4) || (addr[1:0] != 2'b00) || (widx >= TOTAL_W);

    always_comb begin
        rd_idx = widx;
        wr_idx = widx;
        op     = OP_PUT;
        if (widx < ALIAS_END_W) begin
            rd_idx = grp_base;
            wr_idx = grp_base;
            op     = bitop_e'(widx[1:0]);
        end else if (widx < RDO_END_W) begin
            rd_idx = grp_base;
        end
    end

endmodule

// File: rtl/stb_bitop.sv
module stb_bitop
    import stb_pkg::*;
(
    input  bitop_e            op,
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] new_word
);
    always_comb begin
        unique case (op)
            OP_PUT: new_word = wdata;
            OP_SET: new_word = old_word | wdata;
            OP_CLR: new_word = old_word & ~wdata;
            OP_TOG: new_word = old_word ^ wdata;
        endcase
    end

    always_comb begin
        if (op == OP_SET)
            a_r2_set_keeps_old: assert ((new_word & old_word) == old_word);
        if (op == OP_CLR)
            a_r3_clr_drops_masked: assert ((new_word & wdata) == '0);
        if (op == OP_TOG)
            a_r4_tog_reversible: assert ((new_word ^ wdata) == old_word);
    end

endmodule

// File: rtl/stb_store.sv
module stb_store
    import stb_pkg::*;
#(
    parameter int N_ALIAS  = 4,
    parameter int N_PLL    = 2,
    parameter int N_RDO    = 1,
    parameter int N_PLAIN  = 4,
    parameter int IDX_W    = 6,
    parameter int LOCK_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  bitop_e            op,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    localparam int TOTAL     = 4 * N_ALIAS + 4 * N_RDO + N_PLAIN;
    localparam int ALIAS_END = 4 * N_ALIAS;

    logic [WORD_W-1:0] q [TOTAL];
    logic [WORD_W-1:0] tgt_old;
    logic [WORD_W-1:0] tgt_new;

    always_comb begin
        tgt_old = '0;
        rd_data = '0;
        for (int k = 0; k < TOTAL; k++) begin
            if (wr_idx == IDX_W'(k)) tgt_old = q[k];
            if (rd_idx == IDX_W'(k)) rd_data = q[k];
        end
    end

    stb_bitop u_bitop (
        .op       (op),
        .old_word (tgt_old),
        .wdata    (wdata),
        .new_word (tgt_new)
    );

    for (genvar k = 0; k < TOTAL; k++) begin : g_word
        if (k < ALIAS_END && (k % 4) != 0) begin : g_alias_slot
            // alias slot: no storage of its own
            assign q[k] = '0;
        end else begin : g_stored
            localparam logic [WORD_W-1:0] HOME =
                home_value(k, N_ALIAS, N_PLL, N_RDO, LOCK_BIT);
            logic [WORD_W-1:0] w;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    w <= HOME;
                else if (we && wr_idx == IDX_W'(k))
                    w <= tgt_new;
            end
            assign q[k] = w;
        end
    end

    if (N_PLL > 0) begin : g_lock_chk
        a_r1_lock_at_release: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> q[0][LOCK_BIT]);
    end

    a_r8_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q[0]));

endmodule

// File: rtl/alias_regbank.sv
module alias_regbank
    import stb_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int N_ALIAS  = 4,
    parameter int N_PLL    = 2,
    parameter int N_RDO    = 1,
    parameter int N_PLAIN  = 4,
    parameter int LOCK_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic              bad;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    bitop_e            op;
    logic [WORD_W-1:0] rd_data;
    logic              store_we;
    phase_e            phase_q;
    phase_e            phase_d;
    logic [WORD_W-1:0] rdata_q;

    stb_decode #(
        .ADDR_W  (ADDR_W),
        .N_ALIAS (N_ALIAS),
        .N_RDO   (N_RDO),
        .N_PLAIN (N_PLAIN)
    ) u_decode (
        .addr   (req_addr),
        .size   (req_size),
        .bad    (bad),
        .rd_idx (rd_idx),
        .wr_idx (wr_idx),
        .op     (op)
    );

    assign store_we = req_valid && req_write && !bad;

    stb_store #(
        .N_ALIAS  (N_ALIAS),
        .N_PLL    (N_PLL),
        .N_RDO    (N_RDO),
        .N_PLAIN  (N_PLAIN),
        .IDX_W    (IDX_W),
        .LOCK_BIT (LOCK_BIT)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (store_we),
        .wr_idx  (wr_idx),
        .op      (op),
        .wdata   (req_wdata),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // next response phase from the current request
    always_comb begin
        if (!req_valid)     phase_d = PH_IDLE;
        else if (bad)       phase_d = PH_FAULT;
        else if (req_write) phase_d = PH_WR_OK;
        else                phase_d = PH_RD_OK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            rdata_q <= '0;
        end else begin
            phase_q <= phase_d;
            rdata_q <= (phase_d == PH_RD_OK) ? rd_data : '0;
        end
    end

    always_comb begin
        unique case (phase_q)
            PH_IDLE:  begin rsp_valid = 1'b0; rsp_err = 1'b0; end
            PH_RD_OK: begin rsp_valid = 1'b1; rsp_err = 1'b0; end
            PH_WR_OK: begin rsp_valid = 1'b1; rsp_err = 1'b0; end
            PH_FAULT: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
        endcase
    end
    assign rsp_rdata = rdata_q;

    a_r9_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r8_error_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));
    a_r8_bad_is_error: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_size != 3'd4)) |=> rsp_err);
    a_r9_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));

endmodule

// File: tb/alias_regbank_test.sv
module alias_regbank_test;
    localparam int TOTAL = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] model [TOTAL];
    logic        exp_err [$];
    logic [31:0] exp_data [$];
    string       exp_tag [$];

    always #5 clk = ~clk;

    alias_regbank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    function automatic logic [31:0] model_read(int idx);
        if (idx < 16)      return model[idx & ~3];
        else if (idx < 20) return model[16];
        else               return model[idx];
    endfunction

    function automatic void model_write(int idx, logic [31:0] wd);
        int b;
        if (idx < 16) begin
            b = idx & ~3;
            case (idx & 3)
                0: model[b] = wd;
                1: model[b] = model[b] | wd;
                2: model[b] = model[b] & ~wd;
                default: model[b] = model[b] ^ wd;
            endcase
        end else begin
            model[idx] = wd;
        end
    endfunction

    // driver: push expectation, present request for one cycle
    task automatic access(input bit wr, input int idx, input logic [31:0] wd,
                          input int size, input int lo, input string tag);
        bit bad;
        bad = (size != 4) || (lo != 0) || (idx >= TOTAL);
        if (bad) begin
            exp_err.push_back(1'b1); exp_data.push_back('0);
        end else if (wr) begin
            model_write(idx, wd);
            exp_err.push_back(1'b0); exp_data.push_back('0);
        end else begin
            exp_err.push_back(1'b0); exp_data.push_back(model_read(idx));
        end
        exp_tag.push_back(tag);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 8'(idx * 4 + lo);
        req_size  = 3'(size);
        req_wdata = wd;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        req_write = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare responses against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                checks++;
                if (exp_err.size() == 0) begin
                    errors++;
                    $display("FAIL R10: unexpected response err=%0b data=%h expected none",
                             rsp_err, rsp_rdata);
                end else begin
                    automatic logic e_err = exp_err.pop_front();
                    automatic logic [31:0] e_dat = exp_data.pop_front();
                    automatic string t = exp_tag.pop_front();
                    if (rsp_err !== e_err || rsp_rdata !== e_dat) begin
                        errors++;
                        $display("FAIL %s: got err=%0b data=%h expected err=%0b data=%h",
                                 t, rsp_err, rsp_rdata, e_err, e_dat);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < TOTAL; k++) model[k] = '0;
        model[0]  = 32'h8001_3001;
        model[4]  = 32'h8001_1001;
        model[8]  = 32'h0000_5A02;
        model[12] = 32'h0000_5A03;
        model[16] = 32'h0000_0001;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10: rsp_valid=%0b after reset expected 0", rsp_valid);
        end

        // R1 reset values
        access(0, 0,  '0, 4, 0, "R1");
        access(0, 4,  '0, 4, 0, "R1");
        access(0, 8,  '0, 4, 0, "R1");
        access(0, 12, '0, 4, 0, "R1");
        access(0, 16, '0, 4, 0, "R1");
        access(0, 20, '0, 4, 0, "R1");
        access(0, 23, '0, 4, 0, "R1");
        idle(2);

        // R5 alias reads
        access(0, 1, '0, 4, 0, "R5");
        access(0, 2, '0, 4, 0, "R5");
        access(0, 7, '0, 4, 0, "R5");
        idle(1);

        // R2 set, R3 clear, R4 toggle
        access(1, 1, 32'h0000_00F0, 4, 0, "R2");
        idle(1);
        access(0, 0, '0, 4, 0, "R2");
        access(1, 6, 32'h8000_0001, 4, 0, "R3");
        idle(1);
        access(0, 4, '0, 4, 0, "R3");
        access(1, 11, 32'hFFFF_0000, 4, 0, "R4");
        access(0, 8, '0, 4, 0, "R4");
        access(1, 11, 32'hF0F0_0000, 4, 0, "R4");
        access(0, 9, '0, 4, 0, "R4");
        idle(1);

        // R6 whole-word replacement
        access(1, 12, 32'h1234_5678, 4, 0, "R6");
        access(0, 15, '0, 4, 0, "R6");
        access(1, 21, 32'hCAFE_BABE, 4, 0, "R6");
        access(0, 21, '0, 4, 0, "R6");
        idle(1);

        // R7 redirect-only region
        access(1, 17, 32'h0000_DEAD, 4, 0, "R7");
        access(0, 16, '0, 4, 0, "R7");
        access(0, 17, '0, 4, 0, "R7");
        access(1, 16, 32'h0000_0077, 4, 0, "R7");
        access(0, 18, '0, 4, 0, "R7");
        idle(1);

        // R8 bad accesses
        access(0, 0,  '0, 2, 0, "R8");
        access(1, 0,  32'hFFFF_FFFF, 1, 0, "R8");
        access(1, 4,  32'hFFFF_FFFF, 4, 2, "R8");
        access(0, 4,  '0, 4, 1, "R8");
        access(1, 24, 32'h5555_5555, 4, 0, "R8");
        access(0, 40, '0, 4, 0, "R8");
        access(0, 0,  '0, 4, 0, "R8");
        access(0, 4,  '0, 4, 0, "R8");
        idle(1);

        // R9 back-to-back write then read
        access(1, 14, 32'h0000_0F0F, 4, 0, "R9");
        access(0, 12, '0, 4, 0, "R9");
        access(1, 22, 32'hA5A5_0001, 4, 0, "R9");
        access(0, 22, '0, 4, 0, "R9");
        access(1, 5, 32'h0000_0100, 4, 0, "R9");
        access(0, 4, '0, 4, 0, "R9");
        idle(3);

        checks++;
        if (exp_err.size() != 0) begin
            errors++;
            $display("FAIL R9: %0d responses missing expected 0", exp_err.size());
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule